// File: doc/BRIEF.md
# Floating-Point Result Packer

This block takes one unpacked floating-point result per cycle and packs it into a destination format chosen per operation. The result arrives in parts: a sign, a signed true (unbiased) exponent, and a 64-bit normalized significand whose top bit is the integer bit. Below the significand sit a round bit and a sticky bit. Side flags mark a zero result, a zero divisor with the two operand signs, and a denormal source operand. The destination is extended (explicit integer bit, 64-bit significand), double (53 bits, hidden integer bit) or single (24 bits, hidden integer bit).

All exceptions are handled with their masked response. An exponent that is too large gives infinity or the largest finite value, depending on the rounding mode. An exponent that is too small is shifted down to the format's minimum exponent and then rounded, which gives a denormal or a signed zero. A zero divisor gives a signed infinity. Rounding loss raises the precision flag. Exception flags are sticky across operations until they are cleared. The packed word, a class tag and the flags are registered, so results appear one cycle after the input.

Top module: `fp_result_packer`

## Requirements
- R1: A result appears with `out_valid` high exactly one clock after the `in_valid` cycle that produced it. `out_valid` is low in every other cycle.
- R2: The significand is rounded to the format's width. `in_rmode` codes are 0 nearest-even, 1 toward minus infinity, 2 toward plus infinity, 3 chop. Any nonzero rounding loss sets the precision flag.
- R3: The result overflows when its exponent, after rounding, is above +16383 (extended, `in_fmt`=0), +1023 (double, 1) or +127 (single, 2). In modes 0 and 3, overflow gives infinity with the result's sign and tag 2. Every overflow sets the overflow flag and the precision flag.
- R4: In modes 1 and 2, overflow gives the largest finite value with the result's sign and tag 0. That value has the all-ones significand and the biased exponent one below the maximum.
- R5: An input exponent below -16382, -1022 or -126 (per format) sets the underflow flag. The significand is shifted right until the exponent reaches that minimum, then rounded. A nonzero result is stored with biased exponent 0. A result that rounds to zero is a signed zero with tag 1.
- R6: Tag codes are 0 valid, 1 zero, 2 special. An extended-format denormal result carries tag 2. Double and single denormals carry tag 0.
- R7: With `in_zdiv` set, the output is infinity whose sign is `in_sgn_a` XOR `in_sgn_b`, with tag 2. Only the zero-divide flag is raised, and the significand and exponent inputs are ignored.
- R8: `in_dnop` sets the denormal-operand flag, and packing goes on as usual. Denormal-operand, underflow and precision can therefore all be raised by one operation.
- R9: Bias is 16383, 1023 or 127. Extended packs {sign, exponent[14:0], significand[63:0]} into bits 79:0. Double packs {sign, exponent[10:0], fraction[51:0]} into bits 63:0. Single packs {sign, exponent[7:0], fraction[22:0]} into bits 31:0. Unused upper bits are zero.
- R10: `out_flags` bits are [4] denormal operand, [3] zero divide, [2] overflow, [1] underflow, [0] precision. The flags accumulate. `clr_flags` drops the old flags at the next edge, and an operation in that same cycle still adds its own.
- R11: `in_zero` gives a zero with the input sign and tag 1, and raises no flag of its own.
- R12: A rounding carry renormalizes. An all-ones significand rounds up to the next power of two and increments the exponent, which may cause overflow. A denormal that rounds up to the smallest normal gets biased exponent 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_flags | input | 1 | Clear the sticky exception flags |
| in_valid | input | 1 | Result present this cycle |
| in_fmt | input | 2 | Destination format: 0 extended, 1 double, 2 single |
| in_rmode | input | 2 | Rounding mode |
| in_sign | input | 1 | Result sign |
| in_exp | input | EXP_W | Signed true exponent |
| in_sig | input | 64 | Normalized significand, integer bit at 63 |
| in_grd | input | 1 | Round bit below the significand |
| in_stk | input | 1 | Sticky bit below the round bit |
| in_zero | input | 1 | Result is zero |
| in_zdiv | input | 1 | Divisor was zero |
| in_sgn_a | input | 1 | Dividend sign |
| in_sgn_b | input | 1 | Divisor sign |
| in_dnop | input | 1 | A source operand was denormal |
| out_valid | output | 1 | Packed result present |
| out_word | output | 80 | Packed result |
| out_tag | output | 2 | Result class tag |
| out_flags | output | 5 | Sticky exception flags |

## Verification
The bench uses the default EXP_W of 18, so input exponents span about ±131071. This lets stimulus go well outside every format's range. Exponents such as -200 for single exercise a denormalizing shift that is larger than the significand, so the shift clamp and the all-sticky rounding path are tested. Exponents of 20000 reach the extended overflow path, and each format's exact exponent limits are checked on both sides.

// File: rtl/fp_result_packer.sv
module fp_result_packer #(
  parameter int EXP_W = 18,
  parameter int SIG_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_flags,
  input  logic                    in_valid,
  input  logic [1:0]              in_fmt,
  input  logic [1:0]              in_rmode,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0]        in_sig,
  input  logic                    in_grd,
  input  logic                    in_stk,
  input  logic                    in_zero,
  input  logic                    in_zdiv,
  input  logic                    in_sgn_a,
  input  logic                    in_sgn_b,
  input  logic                    in_dnop,
  output logic                    out_valid,
  output logic [SIG_W+15:0]       out_word,
  output logic [1:0]              out_tag,
  output logic [4:0]              out_flags
);

  localparam int OUT_W = SIG_W + 16;
  localparam int WW    = SIG_W + 2;
  localparam int DCAP  = WW + 2;
  localparam int SHW   = $clog2(2 * WW + 8) + 1;

  typedef logic signed [EXP_W:0] et_t;

  function automatic logic [OUT_W-1:0] pack(input logic [1:0] f, input logic s,
                                            input logic [14:0] e, input logic [SIG_W-1:0] m);
    case (f)
      2'd1:    pack = OUT_W'({s, e[10:0], m[51:0]});
      2'd2:    pack = OUT_W'({s, e[7:0], m[22:0]});
      default: pack = {s, e, m};
    endcase
  endfunction

  logic [7:0]       pbits;
  et_t              emin, emax, bias, diff, dsh, eres;
  logic             tiny, rbit, sbit, inx, inc, carry, norm_now, ovf;
  logic [SHW-1:0]   tsh;
  logic [WW-1:0]    wv, kept, rnd, rmask, lmask, one;
  logic [SIG_W-1:0] mant;
  logic [14:0]      biased;
  logic [OUT_W-1:0] nword;
  logic [1:0]       ntag;
  logic [4:0]       nflags;

  assign wv  = {in_sig, in_grd, in_stk};
  assign one = WW'(1);

  always_comb begin
    case (in_fmt)
      2'd1:    begin pbits = 8'd53; emin = et_t'(-1022);  emax = et_t'(1023);  bias = et_t'(1023);  end
      2'd2:    begin pbits = 8'd24; emin = et_t'(-126);   emax = et_t'(127);   bias = et_t'(127);   end
      default: begin pbits = 8'(SIG_W); emin = et_t'(-16382); emax = et_t'(16383); bias = et_t'(16383); end
    endcase
  end

  assign tiny = et_t'(in_exp) < emin;
  assign diff = emin - et_t'(in_exp);
  assign dsh  = !tiny ? '0 : (diff > et_t'(DCAP) ? et_t'(DCAP) : diff);
  assign tsh  = SHW'(WW) - SHW'(pbits) + SHW'(dsh);

  assign kept  = wv >> tsh;
  assign rmask = one << (tsh - SHW'(1));
  assign lmask = rmask - one;
  assign rbit  = |(wv & rmask);
  assign sbit  = |(wv & lmask);
  assign inx   = rbit | sbit;

  always_comb begin
    case (in_rmode)
      2'd0:    inc = rbit & (sbit | kept[0]);
      2'd1:    inc = in_sign & inx;
      2'd2:    inc = ~in_sign & inx;
      default: inc = 1'b0;
    endcase
  end

  assign rnd      = kept + WW'(inc);
  assign carry    = (rnd >> pbits) != '0;
  assign norm_now = |(rnd & (one << (pbits - 8'd1)));
  assign eres     = et_t'(in_exp) + et_t'(carry);
  assign ovf      = !tiny && (eres > emax);
  assign mant     = SIG_W'((carry && !tiny) ? (rnd >> 1) : rnd);
  assign biased   = tiny ? {14'd0, norm_now} : 15'(eres + bias);

  always_comb begin
    nflags = {in_dnop, 4'b0000};
    if (in_zdiv) begin
      nword     = pack(in_fmt, in_sgn_a ^ in_sgn_b, 15'h7FFF, {1'b1, {(SIG_W-1){1'b0}}});
      ntag      = 2'd2;
      nflags[3] = 1'b1;
    end else if (in_zero) begin
      nword = pack(in_fmt, in_sign, 15'd0, '0);
      ntag  = 2'd1;
    end else if (ovf) begin
      nflags[2] = 1'b1;
      nflags[0] = 1'b1;
      if (in_rmode == 2'd1 || in_rmode == 2'd2) begin
        nword = pack(in_fmt, in_sign, 15'h7FFE, '1);
        ntag  = 2'd0;
      end else begin
        nword = pack(in_fmt, in_sign, 15'h7FFF, {1'b1, {(SIG_W-1){1'b0}}});
        ntag  = 2'd2;
      end
    end else begin
      nflags[1] = tiny;
      nflags[0] = inx;
      nword     = pack(in_fmt, in_sign, biased, mant);
      if (tiny && rnd == '0)
        ntag = 2'd1;
      else if (tiny && !norm_now && in_fmt != 2'd1 && in_fmt != 2'd2)
        ntag = 2'd2;
      else
        ntag = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_tag   <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= nword;
        out_tag  <= ntag;
      end
      out_flags <= (clr_flags ? 5'd0 : out_flags) | (in_valid ? nflags : 5'd0);
    end
  end

endmodule

// File: rtl/fp_result_packer_checks.sv
module fp_result_packer_checks #(
  parameter int EXP_W = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr_flags,
  input logic                    in_valid,
  input logic [1:0]              in_fmt,
  input logic signed [EXP_W-1:0] in_exp,
  input logic                    in_zero,
  input logic                    in_zdiv,
  input logic                    in_dnop,
  input logic                    out_valid,
  input logic [1:0]              out_tag,
  input logic [4:0]              out_flags
);

  logic signed [EXP_W:0] lim;
  logic big;

  always_comb begin
    case (in_fmt)
      2'd1:    lim = (EXP_W+1)'(1023);
      2'd2:    lim = (EXP_W+1)'(127);
      default: lim = (EXP_W+1)'(16383);
    endcase
  end
  assign big = (EXP_W+1)'(in_exp) > lim;

  p_valid_next_r1: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  p_ovf_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_zdiv && !in_zero && big) |=> (out_flags[2] && out_flags[0]));
  p_tag_code_r6: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> out_tag != 2'd3);
  p_zdiv_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_zdiv) |=> (out_flags[3] && out_tag == 2'd2));
  p_dnop_flag_r8: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_dnop) |=> out_flags[4]);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_flags |=> ((out_flags & $past(out_flags)) == $past(out_flags)));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flags && !in_valid) |=> out_flags == 5'd0);
  p_zero_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_zero && !in_zdiv) |=> out_tag == 2'd1);

endmodule

bind fp_result_packer fp_result_packer_checks #(.EXP_W(EXP_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .clr_flags(clr_flags), .in_valid(in_valid),
  .in_fmt(in_fmt), .in_exp(in_exp), .in_zero(in_zero), .in_zdiv(in_zdiv),
  .in_dnop(in_dnop), .out_valid(out_valid), .out_tag(out_tag), .out_flags(out_flags)
);

// File: tb/test_fp_result_packer.sv
module test_fp_result_packer;
  localparam int EXP_W = 18;

  logic clk = 1'b0, rst_n = 1'b0, clr_flags = 1'b0, in_valid = 1'b0;
  logic [1:0] in_fmt = 2'd0, in_rmode = 2'd0;
  logic in_sign = 1'b0;
  logic signed [EXP_W-1:0] in_exp = '0;
  logic [63:0] in_sig = '0;
  logic in_grd = 1'b0, in_stk = 1'b0, in_zero = 1'b0, in_zdiv = 1'b0;
  logic in_sgn_a = 1'b0, in_sgn_b = 1'b0, in_dnop = 1'b0;
  logic out_valid;
  logic [79:0] out_word;
  logic [1:0] out_tag;
  logic [4:0] out_flags;

  always #5 clk = ~clk;

  fp_result_packer #(.EXP_W(EXP_W)) i_fp_result_packer (.*);

  int checks = 0, fails = 0, pushed = 0, popped = 0;
  logic [4:0] mflags = '0;
  logic [79:0] q_word[$];
  logic [1:0]  q_tag[$];
  logic [4:0]  q_fl[$];
  string       q_req[$];

  task automatic chk(input string req, input string what, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic op(input string req, input logic [1:0] f, input logic [1:0] rm, input logic s,
                    input int e, input logic [63:0] m, input logic g, input logic st,
                    input logic zr, input logic zd, input logic sa, input logic sb,
                    input logic dn, input logic clr,
                    input logic [79:0] ew, input logic [1:0] et, input logic [4:0] nf);
    mflags = (clr ? 5'd0 : mflags) | nf;
    q_word.push_back(ew); q_tag.push_back(et); q_fl.push_back(mflags); q_req.push_back(req);
    pushed++;
    in_fmt = f; in_rmode = rm; in_sign = s; in_exp = EXP_W'(e); in_sig = m;
    in_grd = g; in_stk = st; in_zero = zr; in_zdiv = zd; in_sgn_a = sa; in_sgn_b = sb;
    in_dnop = dn; clr_flags = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; clr_flags = 1'b0; in_dnop = 1'b0; in_zero = 1'b0; in_zdiv = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_word.size() == 0) begin
        chk("R1", "unexpected out_valid", 80'd1, 80'd0);
      end else begin
        string r;
        r = q_req.pop_front();
        chk(r, "word", out_word, q_word.pop_front());
        chk(r, "tag", 80'(out_tag), 80'(q_tag.pop_front()));
        chk(r, "flags", 80'(out_flags), 80'(q_fl.pop_front()));
        popped++;
      end
    end
  end

  localparam logic [63:0] ONE  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset out_valid", 80'(out_valid), 80'd0);
    chk("R10", "reset flags", 80'(out_flags), 80'd0);
    chk("R9", "reset word", out_word, 80'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 packing
    op("R9", 2, 0, 0, 0, 64'hC000_0000_0000_0000, 0, 0, 0, 0, 0, 0, 0, 1, 80'h3FC0_0000, 0, 5'b00000);
    op("R9", 1, 0, 1, 0, ONE, 0, 0, 0, 0, 0, 0, 0, 0, 80'h0000_BFF0_0000_0000_0000, 0, 5'b00000);
    op("R9", 0, 0, 0, 0, ONE, 0, 0, 0, 0, 0, 0, 0, 0, 80'h3FFF_8000_0000_0000_0000, 0, 5'b00000);
    // R2 rounding modes
    op("R2", 2, 0, 0, 0, 64'h8000_0080_0000_0000, 0, 0, 0, 0, 0, 0, 0, 1, 80'h3F80_0000, 0, 5'b00001);
    op("R2", 2, 2, 0, 0, 64'h8000_0080_0000_0000, 0, 0, 0, 0, 0, 0, 0, 1, 80'h3F80_0001, 0, 5'b00001);
    op("R2", 2, 1, 1, 0, 64'h8000_0080_0000_0000, 0, 0, 0, 0, 0, 0, 0, 1, 80'hBF80_0001, 0, 5'b00001);
    op("R2", 2, 1, 0, 0, 64'h8000_0080_0000_0000, 0, 0, 0, 0, 0, 0, 0, 1, 80'h3F80_0000, 0, 5'b00001);
    op("R2", 2, 3, 1, 0, 64'h8000_0080_0000_0000, 0, 0, 0, 0, 0, 0, 0, 1, 80'hBF80_0000, 0, 5'b00001);
    op("R2", 2, 0, 0, 0, 64'h8000_0180_0000_0000, 0, 0, 0, 0, 0, 0, 0, 1, 80'h3F80_0002, 0, 5'b00001);
    op("R2", 2, 0, 0, 0, ONE, 0, 1, 0, 0, 0, 0, 0, 1, 80'h3F80_0000, 0, 5'b00001);
    op("R2", 2, 2, 0, 0, ONE, 0, 1, 0, 0, 0, 0, 0, 1, 80'h3F80_0001, 0, 5'b00001);
    op("R2", 0, 0, 0, 0, ONE, 1, 0, 0, 0, 0, 0, 0, 1, 80'h3FFF_8000_0000_0000_0000, 0, 5'b00001);
    op("R2", 0, 0, 0, 0, ONE, 1, 1, 0, 0, 0, 0, 0, 1, 80'h3FFF_8000_0000_0000_0001, 0, 5'b00001);
    // R10 sticky: exact op keeps the earlier precision flag
    op("R10", 2, 0, 0, 0, ONE, 0, 0, 0, 0, 0, 0, 0, 0, 80'h3F80_0000, 0, 5'b00000);
    // R12 carry renormalization
    op("R12", 2, 0, 0, 0, ONES, 0, 0, 0, 0, 0, 0, 0, 1, 80'h4000_0000, 0, 5'b00001);
    // R3 overflow thresholds
    op("R3", 2, 0, 0, 127, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'h7F00_0000, 0, 5'b00000);
    op("R3", 2, 0, 0, 128, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'h7F80_0000, 2, 5'b00101);
    op("R3", 1, 3, 1, 1024, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'h0000_FFF0_0000_0000_0000, 2, 5'b00101);
    op("R3", 0, 0, 0, 16384, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'h7FFF_8000_0000_0000_0000, 2, 5'b00101);
    op("R3", 0, 0, 0, 16383, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'h7FFE_8000_0000_0000_0000, 0, 5'b00000);
    // R4 directed-mode overflow
    op("R4", 2, 2, 0, 200, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'h7F7F_FFFF, 0, 5'b00101);
    op("R4", 2, 1, 1, 200, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'hFF7F_FFFF, 0, 5'b00101);
    op("R4", 0, 2, 0, 20000, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'h7FFE_FFFF_FFFF_FFFF_FFFF, 0, 5'b00101);
    op("R12", 2, 0, 0, 127, ONES, 0, 0, 0, 0, 0, 0, 0, 1, 80'h7F80_0000, 2, 5'b00101);
    // R5 underflow
    op("R5", 2, 0, 0, -127, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'h0040_0000, 0, 5'b00010);
    op("R5", 2, 0, 0, -126, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'h0080_0000, 0, 5'b00000);
    op("R5", 2, 0, 1, -200, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'h8000_0000, 1, 5'b00011);
    op("R5", 2, 2, 0, -200, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'h0000_0001, 0, 5'b00011);
    op("R5", 1, 0, 0, -1023, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'h0000_0008_0000_0000_0000, 0, 5'b00010);
    op("R6", 0, 0, 0, -16383, ONE, 0, 0, 0, 0, 0, 0, 0, 1, 80'h0000_4000_0000_0000_0000, 2, 5'b00010);
    op("R12", 2, 0, 0, -127, ONES, 0, 0, 0, 0, 0, 0, 0, 1, 80'h0080_0000, 0, 5'b00011);
    // R7 zero divide
    op("R7", 1, 0, 0, 5000, ONES, 1, 1, 0, 1, 1, 0, 0, 1, 80'h0000_FFF0_0000_0000_0000, 2, 5'b01000);
    op("R7", 0, 0, 1, 0, ONES, 0, 0, 0, 1, 1, 1, 0, 1, 80'h7FFF_8000_0000_0000_0000, 2, 5'b01000);
    // R8 denormal operand with underflow and precision
    op("R8", 2, 0, 0, -130, 64'h8000_0000_0000_0001, 0, 0, 0, 0, 0, 0, 1, 1, 80'h0008_0000, 0, 5'b10011);
    op("R8", 0, 0, 0, 0, ONE, 0, 0, 0, 0, 0, 0, 1, 1, 80'h3FFF_8000_0000_0000_0000, 0, 5'b10000);
    // R11 zero inputs
    op("R11", 1, 0, 1, 77, ONES, 1, 1, 1, 0, 0, 0, 0, 1, 80'h0000_8000_0000_0000_0000, 1, 5'b00000);
    op("R11", 0, 2, 0, 3, ONES, 1, 1, 1, 0, 0, 0, 0, 0, 80'h0, 1, 5'b00000);
    // R10 clear without an operation
    op("R10", 2, 0, 0, 0, ONE, 0, 1, 0, 0, 0, 0, 0, 0, 80'h3F80_0000, 0, 5'b00001);
    @(negedge clk);
    clr_flags = 1'b1;
    @(negedge clk);
    clr_flags = 1'b0;
    mflags = '0;
    chk("R10", "flags after clear", 80'(out_flags), 80'd0);
    chk("R1", "out_valid idle", 80'(out_valid), 80'd0);
    @(negedge clk);
    chk("R1", "all results seen", 80'(popped), 80'(pushed));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule